// File: doc/BRIEF.md
# Checkpointed Rename Map with Random-Access Snapshots

This block holds the speculative map from architectural register names to physical register names for a superscalar rename stage. Each cycle up to `LANES` instructions look up their two source operands and the mapping their destination is about to replace. Each instruction may also install a new destination mapping. Lookups in a later lane see the writes made by earlier lanes of the same bundle, so a bundle behaves exactly like the same instructions renamed one at a time.

A bank of `NCK` snapshot slots sits beside the main map. Each slot has its own copy-in and copy-out control, so saving into any slot or restoring from any slot takes one cycle, whatever its position. A controller hands slots out to branches in program order and keeps a valid bit and an age tag for every slot. Slots are released oldest first. Under the selective policy only branches marked low-confidence get a slot. A branch that is refused a slot is given the tag of the next slot to be handed out. If that branch mispredicts, the map is restored from that younger snapshot, when it still exists. The block then asks for the remaining instructions to be undone through an external history log, which feeds the old mappings back through an undo port.

Top module: `rat_ckpt_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i, no snapshot slot is in use, and the first granted snapshot tag is 0.
- R2: A source lookup returns the current mapping of the named architectural register. The replaced-mapping output returns the current mapping of the lane's destination.
- R3: Within one bundle, a lane's lookups return the newest mapping written by an enabled lower-numbered lane to the same register. When several lanes write the same register, the highest-numbered lane's mapping is the one kept.
- R4: Under the all-branches policy (policy_sel=0), a branch is granted a snapshot whenever fewer than NCK slots are in use. Tags are TAG_W = log2(NCK)+1 bits wide and are granted in increasing order modulo 2·NCK. The slot is the tag's low log2(NCK) bits. The snapshot holds the map as it stands after that cycle's bundle.
- R5: Under the selective policy (policy_sel=1), a branch with br_low_conf=0 is never granted a snapshot, even when slots are free. A branch with br_low_conf=1 is treated as in R4.
- R6: When all NCK slots are in use, br_ckpt_got is 0 and br_ckpt_tag shows the tag that the next granted snapshot will carry.
- R7: ck_free releases the oldest snapshot in use. A slot released this way can be granted again from the next cycle.
- R8: rec_valid with rec_exact=1 and the tag of a live snapshot replaces the whole map with that snapshot at the next clock edge, for any slot. In the following cycle rec_hit=1 and rec_walk=0.
- R9: A restore releases the restored snapshot and every younger one, and the next grant reuses the restored tag. Older snapshots stay live and can still be restored.
- R10: With rec_exact=0, a live snapshot whose tag equals rec_tag is restored as in R8, and rec_hit=1 and rec_walk=1 follow. If no live slot holds that exact tag, the map is left unchanged, rec_hit=0 and rec_walk=1. An exact request for a dead tag also gives rec_hit=0 and rec_walk=1.
- R11: undo_valid writes undo_phys into entry undo_arch. In that cycle the rename writes and branch grants are suppressed.
- R12: In a cycle with rec_valid, rename writes, branch grants and ck_free have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 1 | 0: every branch may get a snapshot; 1: low-confidence branches only |
| ren_src_a | input | LANES x ARCH_W | First source architectural register per lane |
| ren_src_b | input | LANES x ARCH_W | Second source architectural register per lane |
| ren_dst | input | LANES x ARCH_W | Destination architectural register per lane |
| ren_dst_en | input | LANES | Lane installs a new destination mapping |
| ren_dst_new | input | LANES x PHYS_W | Newly allocated physical register per lane |
| ren_src_a_phys | output | LANES x PHYS_W | Physical name for the first source |
| ren_src_b_phys | output | LANES x PHYS_W | Physical name for the second source |
| ren_old_phys | output | LANES x PHYS_W | Mapping being replaced for the destination |
| br_valid | input | 1 | A branch closes this bundle |
| br_low_conf | input | 1 | Branch predicted with low confidence |
| br_ckpt_got | output | 1 | Snapshot granted to this branch |
| br_ckpt_tag | output | TAG_W | Granted tag, or the tag the next grant will carry |
| ck_free | input | 1 | Release the oldest snapshot |
| rec_valid | input | 1 | Misprediction recovery request |
| rec_exact | input | 1 | The branch owns the snapshot named by rec_tag |
| rec_tag | input | TAG_W | Tag recorded for the mispredicted branch |
| rec_hit | output | 1 | Previous cycle's recovery restored a snapshot |
| rec_walk | output | 1 | Previous cycle's recovery needs a log walk-back |
| undo_valid | input | 1 | Walk-back write is present |
| undo_arch | input | ARCH_W | Architectural register being undone |
| undo_phys | input | PHYS_W | Mapping to put back |

## Verification
A corrupted snapshot slot stays hidden until it is restored. It then shows up at the source-lookup outputs one cycle after the recovery request, as a mismatch in every entry written since the branch. The bench therefore sweeps the whole map through the lookup ports after each restore. A wrong valid bit or a drifted head or tail pointer surfaces at the grant outputs on the next branch: a wrong tag, a grant when the bank is full, or a refusal when a slot is free. Mistakes in the bypass chain are visible in the same cycle as the lookup outputs of the higher lanes.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int DEF_ARCH_N = 16;
    localparam int DEF_PHYS_W = 6;
    localparam int DEF_LANES  = 2;
    localparam int DEF_NCK    = 4;
endpackage

// File: rtl/rat_lane_xlate.sv
module rat_lane_xlate #(
    parameter int ARCH_N = 16,
    parameter int ARCH_W = 4,
    parameter int PHYS_W = 6,
    parameter int LANES  = 2
) (
    input  logic [ARCH_N-1:0][PHYS_W-1:0] map_q,
    input  logic [LANES-1:0][ARCH_W-1:0]  src_a,
    input  logic [LANES-1:0][ARCH_W-1:0]  src_b,
    input  logic [LANES-1:0][ARCH_W-1:0]  dst,
    input  logic [LANES-1:0]              dst_en,
    input  logic [LANES-1:0][PHYS_W-1:0]  dst_new,
    output logic [LANES-1:0][PHYS_W-1:0]  a_phys,
    output logic [LANES-1:0][PHYS_W-1:0]  b_phys,
    output logic [LANES-1:0][PHYS_W-1:0]  o_phys,
    output logic [ARCH_N-1:0][PHYS_W-1:0] map_upd
);
    // Lane j starts from the committed map and is overridden by every
    // enabled lane below it, in ascending order, so the nearest one wins.
    always_comb begin
        map_upd = map_q;
        for (int j = 0; j < LANES; j++) begin
            a_phys[j] = map_q[src_a[j]];
            b_phys[j] = map_q[src_b[j]];
            o_phys[j] = map_q[dst[j]];
            for (int i = 0; i < j; i++) begin
                if (dst_en[i]) begin
                    if (dst[i] == src_a[j]) a_phys[j] = dst_new[i];
                    if (dst[i] == src_b[j]) b_phys[j] = dst_new[i];
                    if (dst[i] == dst[j])   o_phys[j] = dst_new[i];
                end
            end
            if (dst_en[j]) map_upd[dst[j]] = dst_new[j];
        end
    end
endmodule

// File: rtl/rat_ckpt_slot.sv
module rat_ckpt_slot #(
    parameter int ARCH_N = 16,
    parameter int PHYS_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cp_in,
    input  logic                          cp_out,
    input  logic [ARCH_N-1:0][PHYS_W-1:0] snap_in,
    output logic [ARCH_N-1:0][PHYS_W-1:0] snap_out
);
    logic [ARCH_N-1:0][PHYS_W-1:0] store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (cp_in) store_d = snap_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    // Copy-out gate: only the selected slot drives the shared restore bus.
    assign snap_out = cp_out ? store_q : '0;
endmodule

// File: rtl/rat_ckpt_ctrl.sv
module rat_ckpt_ctrl #(
    parameter int NCK   = 4,
    parameter int CK_W  = $clog2(NCK),
    parameter int TAG_W = CK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_sel,
    input  logic             br_valid,
    input  logic             br_low_conf,
    input  logic             undo_busy,
    input  logic             ck_free,
    input  logic             rec_valid,
    input  logic             rec_exact,
    input  logic [TAG_W-1:0] rec_tag,
    output logic             grant,
    output logic [TAG_W-1:0] grant_tag,
    output logic [NCK-1:0]   cp_in,
    output logic [NCK-1:0]   cp_out,
    output logic             restore_en,
    output logic [CK_W-1:0]  restore_slot,
    output logic [NCK-1:0]   slot_valid,
    output logic             rec_hit,
    output logic             rec_walk
);
    typedef struct packed {
        logic [TAG_W-1:0]            head;
        logic [TAG_W-1:0]            tail;
        logic [NCK-1:0]              vld;
        logic [NCK-1:0][TAG_W-1:0]   tags;
        logic                        hit;
        logic                        walk;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [TAG_W-1:0] in_use;
    logic             full;
    logic             want;
    logic             match;
    logic [CK_W-1:0]  head_slot;
    logic [CK_W-1:0]  tail_slot;
    logic [CK_W-1:0]  rage;
    logic [CK_W-1:0]  age;

    always_comb begin
        st_d       = st_q;
        in_use     = st_q.tail - st_q.head;
        full       = (in_use == TAG_W'(NCK));
        head_slot  = st_q.head[CK_W-1:0];
        tail_slot  = st_q.tail[CK_W-1:0];
        want       = br_valid && (!policy_sel || br_low_conf) && !rec_valid && !undo_busy;
        grant      = want && !full;
        grant_tag  = st_q.tail;
        cp_in      = '0;
        cp_out     = '0;
        restore_slot = rec_tag[CK_W-1:0];
        match      = st_q.vld[restore_slot] && (st_q.tags[restore_slot] == rec_tag);
        restore_en = rec_valid && match;
        rage       = restore_slot - head_slot;
        age        = '0;

        st_d.hit   = restore_en;
        st_d.walk  = rec_valid && (!rec_exact || !match);

        if (rec_valid) begin
            if (match) begin
                cp_out[restore_slot] = 1'b1;
                st_d.tail = rec_tag;
                // Release the restored slot and everything allocated after it.
                for (int i = 0; i < NCK; i++) begin
                    age = CK_W'(i) - head_slot;
                    if (age >= rage) st_d.vld[i] = 1'b0;
                end
            end
        end else begin
            if (ck_free && (in_use != '0)) begin
                st_d.vld[head_slot] = 1'b0;
                st_d.head = st_q.head + 1'b1;
            end
            if (grant) begin
                cp_in[tail_slot]     = 1'b1;
                st_d.vld[tail_slot]  = 1'b1;
                st_d.tags[tail_slot] = st_q.tail;
                st_d.tail            = st_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_valid = st_q.vld;
    assign rec_hit    = st_q.hit;
    assign rec_walk   = st_q.walk;
endmodule

// File: rtl/rat_ckpt_table.sv
module rat_ckpt_table
    import rat_pkg::*;
#(
    parameter int ARCH_N = DEF_ARCH_N,
    parameter int PHYS_W = DEF_PHYS_W,
    parameter int LANES  = DEF_LANES,
    parameter int NCK    = DEF_NCK,
    localparam int ARCH_W = $clog2(ARCH_N),
    localparam int CK_W   = $clog2(NCK),
    localparam int TAG_W  = CK_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         policy_sel,
    input  logic [LANES-1:0][ARCH_W-1:0] ren_src_a,
    input  logic [LANES-1:0][ARCH_W-1:0] ren_src_b,
    input  logic [LANES-1:0][ARCH_W-1:0] ren_dst,
    input  logic [LANES-1:0]             ren_dst_en,
    input  logic [LANES-1:0][PHYS_W-1:0] ren_dst_new,
    output logic [LANES-1:0][PHYS_W-1:0] ren_src_a_phys,
    output logic [LANES-1:0][PHYS_W-1:0] ren_src_b_phys,
    output logic [LANES-1:0][PHYS_W-1:0] ren_old_phys,
    input  logic                         br_valid,
    input  logic                         br_low_conf,
    output logic                         br_ckpt_got,
    output logic [TAG_W-1:0]             br_ckpt_tag,
    input  logic                         ck_free,
    input  logic                         rec_valid,
    input  logic                         rec_exact,
    input  logic [TAG_W-1:0]             rec_tag,
    output logic                         rec_hit,
    output logic                         rec_walk,
    input  logic                         undo_valid,
    input  logic [ARCH_W-1:0]            undo_arch,
    input  logic [PHYS_W-1:0]            undo_phys
);
    typedef logic [ARCH_N-1:0][PHYS_W-1:0] map_t;

    typedef struct packed {
        map_t map;
    } top_st_t;

    top_st_t st_d, st_q;

    map_t             map_upd;
    map_t             restore_bus;
    map_t             slot_out [NCK];
    logic [NCK-1:0]   cp_in;
    logic [NCK-1:0]   cp_out;
    logic [NCK-1:0]   ck_valid;
    logic             restore_en;
    logic [CK_W-1:0]  restore_slot;

    rat_lane_xlate #(
        .ARCH_N (ARCH_N),
        .ARCH_W (ARCH_W),
        .PHYS_W (PHYS_W),
        .LANES  (LANES)
    ) xlate_i (
        .map_q   (st_q.map),
        .src_a   (ren_src_a),
        .src_b   (ren_src_b),
        .dst     (ren_dst),
        .dst_en  (ren_dst_en),
        .dst_new (ren_dst_new),
        .a_phys  (ren_src_a_phys),
        .b_phys  (ren_src_b_phys),
        .o_phys  (ren_old_phys),
        .map_upd (map_upd)
    );

    rat_ckpt_ctrl #(
        .NCK   (NCK),
        .CK_W  (CK_W),
        .TAG_W (TAG_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy_sel   (policy_sel),
        .br_valid     (br_valid),
        .br_low_conf  (br_low_conf),
        .undo_busy    (undo_valid),
        .ck_free      (ck_free),
        .rec_valid    (rec_valid),
        .rec_exact    (rec_exact),
        .rec_tag      (rec_tag),
        .grant        (br_ckpt_got),
        .grant_tag    (br_ckpt_tag),
        .cp_in        (cp_in),
        .cp_out       (cp_out),
        .restore_en   (restore_en),
        .restore_slot (restore_slot),
        .slot_valid   (ck_valid),
        .rec_hit      (rec_hit),
        .rec_walk     (rec_walk)
    );

    for (genvar g = 0; g < NCK; g++) begin : g_slot
        rat_ckpt_slot #(
            .ARCH_N (ARCH_N),
            .PHYS_W (PHYS_W)
        ) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cp_in    (cp_in[g]),
            .cp_out   (cp_out[g]),
            .snap_in  (map_upd),
            .snap_out (slot_out[g])
        );
    end

    // At most one slot drives a non-zero value, so an OR merges the bus.
    always_comb begin
        restore_bus = '0;
        for (int k = 0; k < NCK; k++) restore_bus = restore_bus | slot_out[k];
    end

    always_comb begin
        st_d = st_q;
        if (restore_en) begin
            st_d.map = restore_bus;
        end else if (rec_valid) begin
            st_d.map = st_q.map;
        end else if (undo_valid) begin
            st_d.map[undo_arch] = undo_phys;
        end else begin
            st_d.map = map_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ARCH_N; k++) st_q.map[k] <= PHYS_W'(k);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rat_ckpt_table_chk.sv
module rat_ckpt_table_chk #(
    parameter int NCK   = 4,
    parameter int CK_W  = 2,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             policy_sel,
    input logic             br_valid,
    input logic             br_low_conf,
    input logic             br_ckpt_got,
    input logic [TAG_W-1:0] br_ckpt_tag,
    input logic             ck_free,
    input logic             rec_valid,
    input logic             rec_hit,
    input logic             rec_walk,
    input logic             undo_valid,
    input logic [NCK-1:0]   ck_valid,
    input logic             restore_en,
    input logic [CK_W-1:0]  restore_slot
);
    a_r5_selective_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_sel && br_valid && !br_low_conf) |-> !br_ckpt_got);

    a_r12_recovery_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !br_ckpt_got);

    a_r11_undo_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        undo_valid |-> !br_ckpt_got);

    a_r4_grant_marks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        br_ckpt_got |=> ck_valid[$past(br_ckpt_tag[CK_W-1:0])]);

    a_r6_full_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ck_valid) == NCK) |-> !br_ckpt_got);

    a_r8_outcome_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_hit || rec_walk) |-> $past(rec_valid));

    a_r9_restored_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> !ck_valid[$past(restore_slot)]);

    a_r7_free_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_free && !rec_valid && (ck_valid != '0))
            |=> ($countones(ck_valid) <= $past($countones(ck_valid))));
endmodule

bind rat_ckpt_table rat_ckpt_table_chk #(
    .NCK   (NCK),
    .CK_W  (CK_W),
    .TAG_W (TAG_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_sel   (policy_sel),
    .br_valid     (br_valid),
    .br_low_conf  (br_low_conf),
    .br_ckpt_got  (br_ckpt_got),
    .br_ckpt_tag  (br_ckpt_tag),
    .ck_free      (ck_free),
    .rec_valid    (rec_valid),
    .rec_hit      (rec_hit),
    .rec_walk     (rec_walk),
    .undo_valid   (undo_valid),
    .ck_valid     (ck_valid),
    .restore_en   (restore_en),
    .restore_slot (restore_slot)
);

// File: tb/rat_ckpt_table_tb.sv
module rat_ckpt_table_tb_top;
    localparam int ARCH_N = 16;
    localparam int ARCH_W = 4;
    localparam int PHYS_W = 6;
    localparam int LANES  = 2;
    localparam int NCK    = 4;
    localparam int TAG_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                         policy_sel;
    logic [LANES-1:0][ARCH_W-1:0] ren_src_a, ren_src_b, ren_dst;
    logic [LANES-1:0]             ren_dst_en;
    logic [LANES-1:0][PHYS_W-1:0] ren_dst_new;
    logic [LANES-1:0][PHYS_W-1:0] ren_src_a_phys, ren_src_b_phys, ren_old_phys;
    logic                         br_valid, br_low_conf, br_ckpt_got;
    logic [TAG_W-1:0]             br_ckpt_tag;
    logic                         ck_free, rec_valid, rec_exact, rec_hit, rec_walk;
    logic [TAG_W-1:0]             rec_tag;
    logic                         undo_valid;
    logic [ARCH_W-1:0]            undo_arch;
    logic [PHYS_W-1:0]            undo_phys;

    rat_ckpt_table dut_i (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_dst_en(ren_dst_en), .ren_dst_new(ren_dst_new),
        .ren_src_a_phys(ren_src_a_phys), .ren_src_b_phys(ren_src_b_phys),
        .ren_old_phys(ren_old_phys),
        .br_valid(br_valid), .br_low_conf(br_low_conf),
        .br_ckpt_got(br_ckpt_got), .br_ckpt_tag(br_ckpt_tag),
        .ck_free(ck_free), .rec_valid(rec_valid), .rec_exact(rec_exact),
        .rec_tag(rec_tag), .rec_hit(rec_hit), .rec_walk(rec_walk),
        .undo_valid(undo_valid), .undo_arch(undo_arch), .undo_phys(undo_phys)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [PHYS_W-1:0] ref_map [ARCH_N];
    logic [PHYS_W-1:0] snap [8][ARCH_N];
    logic [TAG_W-1:0]  b_head, b_tail;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ren_src_a = '0; ren_src_b = '0; ren_dst = '0; ren_dst_en = '0; ren_dst_new = '0;
        br_valid = 0; br_low_conf = 0; ck_free = 0;
        rec_valid = 0; rec_exact = 0; rec_tag = '0;
        undo_valid = 0; undo_arch = '0; undo_phys = '0;
    endtask

    // Sweep every map entry through the lookup ports (no state change).
    task automatic read_all(input string req);
        ren_dst_en = '0;
        for (int a = 0; a < ARCH_N; a += 4) begin
            ren_src_a[0] = ARCH_W'(a);     ren_src_b[0] = ARCH_W'(a + 1);
            ren_src_a[1] = ARCH_W'(a + 2); ren_src_b[1] = ARCH_W'(a + 3);
            #1;
            chk(req, "map entry", ren_src_a_phys[0], ref_map[a]);
            chk(req, "map entry", ren_src_b_phys[0], ref_map[a + 1]);
            chk(req, "map entry", ren_src_a_phys[1], ref_map[a + 2]);
            chk(req, "map entry", ren_src_b_phys[1], ref_map[a + 3]);
        end
        idle();
    endtask

    // One cycle from a negedge to the next: optional lane-0 write,
    // branch, free and undo; checks the grant outputs and updates the model.
    task automatic step(input string req, input logic e0, input logic [3:0] d0, input logic [5:0] n0,
                        input logic br, input logic lowc, input logic fr,
                        input logic und, input logic [3:0] ua, input logic [5:0] up);
        logic [TAG_W-1:0] used;
        logic exp_got;
        ren_dst_en[0] = e0; ren_dst[0] = d0; ren_dst_new[0] = n0;
        br_valid = br; br_low_conf = lowc; ck_free = fr;
        undo_valid = und; undo_arch = ua; undo_phys = up;
        used = b_tail - b_head;
        exp_got = br && !und && (!policy_sel || lowc) && (used != 3'd4);
        #2;
        if (br) begin
            chk(req, "br_ckpt_got", br_ckpt_got, exp_got);
            chk(req, "br_ckpt_tag", br_ckpt_tag, b_tail);
        end
        @(posedge clk);
        @(negedge clk);
        idle();
        if (und) ref_map[ua] = up;
        else if (e0) ref_map[d0] = n0;
        if (fr && used != 0) b_head = b_head + 1'b1;
        if (exp_got) begin
            for (int k = 0; k < ARCH_N; k++) snap[b_tail][k] = ref_map[k];
            b_tail = b_tail + 1'b1;
        end
    endtask

    // Recovery cycle, with a rename write, a branch and a free driven
    // alongside to show they are dropped (R12).
    task automatic recover(input string req, input logic [TAG_W-1:0] tag, input logic exact,
                           input logic exp_hit, input logic exp_walk);
        rec_valid = 1; rec_exact = exact; rec_tag = tag;
        ren_dst_en[0] = 1; ren_dst[0] = 4'd0; ren_dst_new[0] = 6'd63;
        br_valid = 1; br_low_conf = 1; ck_free = 1;
        #2;
        chk("R12", "grant during recovery", br_ckpt_got, 1'b0);
        @(posedge clk);
        @(negedge clk);
        idle();
        chk(req, "rec_hit", rec_hit, exp_hit);
        chk(req, "rec_walk", rec_walk, exp_walk);
        if (exp_hit) begin
            for (int k = 0; k < ARCH_N; k++) ref_map[k] = snap[tag][k];
            b_tail = tag;
        end
        read_all(req);
    endtask

    task automatic t_reset();
        for (int k = 0; k < ARCH_N; k++) ref_map[k] = PHYS_W'(k);
        read_all("R1");
        chk("R1", "rec_hit", rec_hit, 1'b0);
        chk("R1", "rec_walk", rec_walk, 1'b0);
    endtask

    task automatic t_bundle();
        // R2/R3: lane0 writes r3->40, lane1 reads r3,r5 and rewrites r3->41.
        ren_src_a[0] = 4'd3; ren_src_b[0] = 4'd7;
        ren_dst[0] = 4'd3; ren_dst_en[0] = 1; ren_dst_new[0] = 6'd40;
        ren_src_a[1] = 4'd3; ren_src_b[1] = 4'd5;
        ren_dst[1] = 4'd3; ren_dst_en[1] = 1; ren_dst_new[1] = 6'd41;
        #2;
        chk("R2", "lane0 src_a", ren_src_a_phys[0], 6'd3);
        chk("R2", "lane0 src_b", ren_src_b_phys[0], 6'd7);
        chk("R2", "lane0 old", ren_old_phys[0], 6'd3);
        chk("R3", "lane1 src_a bypass", ren_src_a_phys[1], 6'd40);
        chk("R2", "lane1 src_b", ren_src_b_phys[1], 6'd5);
        chk("R3", "lane1 old bypass", ren_old_phys[1], 6'd40);
        @(posedge clk);
        @(negedge clk);
        idle();
        ref_map[3] = 6'd41;
        read_all("R3");
    endtask

    task automatic t_fill();
        policy_sel = 0;
        for (int k = 0; k < 4; k++)
            step("R4", 1, 4'(k + 1), 6'(48 + k), 1, 0, 0, 0, 4'd0, 6'd0);
        step("R6", 1, 4'd6, 6'd60, 1, 0, 0, 0, 4'd0, 6'd0);
        read_all("R4");
    endtask

    task automatic t_restore();
        recover("R8", 3'd2, 1, 1, 0);
        step("R9", 1, 4'd8, 6'd30, 1, 0, 0, 0, 4'd0, 6'd0);
        recover("R10", 3'd3, 1, 0, 1);
        recover("R9", 3'd1, 1, 1, 0);
    endtask

    task automatic t_free();
        for (int k = 0; k < 3; k++)
            step("R4", 1, 4'(k + 12), 6'(20 + k), 1, 0, 0, 0, 4'd0, 6'd0);
        step("R6", 0, 4'd0, 6'd0, 1, 0, 0, 0, 4'd0, 6'd0);
        step("R7", 0, 4'd0, 6'd0, 0, 0, 1, 0, 4'd0, 6'd0);
        step("R7", 1, 4'd2, 6'd17, 1, 0, 0, 0, 4'd0, 6'd0);
    endtask

    task automatic t_younger();
        step("R6", 1, 4'd10, 6'd23, 1, 0, 0, 0, 4'd0, 6'd0);
        step("R7", 0, 4'd0, 6'd0, 0, 0, 1, 0, 4'd0, 6'd0);
        step("R4", 1, 4'd11, 6'd24, 1, 0, 0, 0, 4'd0, 6'd0);
        step("R10", 1, 4'd12, 6'd25, 0, 0, 0, 0, 4'd0, 6'd0);
        recover("R10", 3'd5, 0, 1, 1);
        recover("R10", 3'd6, 0, 0, 1);
    endtask

    task automatic t_selective();
        policy_sel = 1;
        step("R5", 1, 4'd13, 6'd26, 1, 0, 0, 0, 4'd0, 6'd0);
        step("R5", 1, 4'd14, 6'd27, 1, 1, 0, 0, 4'd0, 6'd0);
        read_all("R5");
    endtask

    task automatic t_undo();
        step("R7", 0, 4'd0, 6'd0, 0, 0, 1, 0, 4'd0, 6'd0);
        step("R11", 1, 4'd9, 6'd44, 1, 1, 0, 1, 4'd9, 6'd12);
        read_all("R11");
        step("R11", 0, 4'd0, 6'd0, 1, 1, 0, 0, 4'd0, 6'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        policy_sel = 0;
        b_head = '0;
        b_tail = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bundle();
        t_fill();
        t_restore();
        t_free();
        t_younger();
        t_selective();
        t_undo();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule